// File: doc/BRIEF.md
# I2C Master Transfer Sequencer

This block is the byte-level engine of an I2C master. Software programs it through a small register window. The window holds a control word, a device-address register, a register-address register, transmit and receive byte counts, an event-enable mask, an event-pending register, and a 32-byte transmit buffer and 32-byte receive buffer. The engine turns the programmed transfer into a stream of bus operations: START, STOP, WRITE byte, and READ byte with an ACK/NACK choice. A separate bit-level engine, which owns SCL timing and the pins, carries these operations out.

Three modes are supported.
- Plain transmit sends bytes from the transmit buffer.
- Register-transmit sends the valid device-address and register-address bytes, issues a repeated START with the read address, then reads.
- Plain receive reads bytes into the receive buffer.

After a phase finishes, the engine holds the bus. Software then either requests a STOP or writes a new count to continue with another chunk. Events raise pending flags, and the interrupt line is the OR of each pending flag with its enable.

The bus-operation interface is a pair of valid/ready streams with one operation outstanding at a time.
- The command stream (`cmd_*`) is raised by the engine. It holds op, data and ack choice steady until `cmd_ready`, so the bit engine may stall for as long as it likes.
- The engine then raises `rsp_ready` and waits for `rsp_valid`. It never issues a new command while a response is outstanding.

Top module: `i2c_xfer_seq`

## Requirements
- R1: Control word at offset 0x00 has these fields: bit 0 enable, bits 2:1 mode (0 transmit, 1 register-transmit, 2 or 3 receive), bit 3 start, bit 4 stop, bit 5 last-NACK, bit 6 act-on-NACK. The written value reads back unchanged.
- R2: Buffers are eight 32-bit words. The transmit window is at 0x40 and the receive window at 0x60. Byte k sits in word k/4 at bits 8*(k%4)+7:8*(k%4).
- R3: In transmit mode, after START, the engine writes transmit-count bytes from buffer byte 0 upward. Each write sets event bit 0, and the finished phase sets event bit 2.
- R4: The register-transmit sequence is as follows. Device-address register (0x04) and register-address register (0x08) bytes i in bits 8i+7:8i are sent only when bit 24+i is set, lowest index first, device bytes first. Then comes a repeated START, then a WRITE of device byte 0 with bit 0 set, then the reads.
- R5: In receive, each read stores its byte in receive buffer byte k and sets event bit 1. The read of the final byte of a chunk asks for NACK exactly when last-NACK is 1. The finished phase sets event bit 3.
- R6: While holding after a phase, a write to the receive count (0x10) starts a new receive chunk at buffer byte 0 without a START. A write to the transmit count (0x0C) does the same for transmit mode.
- R7: A NACK on a WRITE with act-on-NACK set sets event bit 6, issues STOP and skips the remaining bytes. With act-on-NACK clear the transfer continues.
- R8: Counts above 32 read back and act as 32. A count of 0 finishes its phase with no byte operation.
- R9: A start request is acted on only when the engine is idle. A start written during a transfer issues no extra START.
- R10: Clearing enable drops any pending command at once and returns the engine to idle. A later start works normally.
- R11: Every START completes with event bit 4. A set stop bit while holding issues STOP, whose completion sets event bit 5 and returns to idle.
- R12: Writing 1s to the pending register (0x18) clears those bits. `irq` is high exactly when some pending bit has its enable bit (0x14) set.
- R13: Command op codes are 0 START, 1 STOP, 2 WRITE, 3 READ. An unaccepted command keeps its op. `rsp_ready` is never high together with `cmd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 7 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cmd_valid | output | 1 | Bus operation offered |
| cmd_ready | input | 1 | Bit engine accepts the operation |
| cmd_op | output | 2 | Operation code |
| cmd_data | output | 8 | Byte to write |
| cmd_nack | output | 1 | For READ: answer with NACK |
| rsp_valid | input | 1 | Operation completed |
| rsp_ready | output | 1 | Engine awaiting completion |
| rsp_data | input | 8 | Byte read |
| rsp_nack | input | 1 | WRITE was not acknowledged |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a start request or an enable drop landing in the middle of an operation. That needs the bit engine to hold off or be mid-transfer at a known instant. The bench's bit-engine model has a stall control that keeps `cmd_ready` low, freezing the block with a START offered. Enable is cleared in that frozen state, and a second start is written a few cycles into a running transmit. Continuation chunks are reached by leaving stop clear so the engine holds, then rewriting the count. A partially overwritten receive word exposes the byte-lane ordering.

// File: rtl/i2cseq_pkg.sv
`timescale 1ns/1ps
package i2cseq_pkg;
  typedef enum logic [1:0] {OP_START = 2'd0, OP_STOP = 2'd1, OP_WRITE = 2'd2, OP_READ = 2'd3} bus_op_e;
  typedef enum logic [1:0] {MODE_TX = 2'd0, MODE_REGTX = 2'd1, MODE_RX = 2'd2, MODE_RX2 = 2'd3} xfer_mode_e;
  typedef struct packed {
    logic       act_nack;
    logic       last_nack;
    logic       stop;
    logic       start;
    logic [1:0] mode;
    logic       en;
  } ctrl_t;
  typedef enum logic [3:0] {
    S_IDLE, S_START, S_ADDR, S_RESTART, S_RADDR, S_TX, S_RX, S_HOLD, S_STOP
  } seq_state_e;
  localparam int EV_W      = 7;
  localparam int EV_BTX    = 0;
  localparam int EV_BRX    = 1;
  localparam int EV_TXDONE = 2;
  localparam int EV_RXDONE = 3;
  localparam int EV_START  = 4;
  localparam int EV_STOP   = 5;
  localparam int EV_NACK   = 6;
  localparam logic [6:0] A_CTRL  = 7'h00;
  localparam logic [6:0] A_DEV   = 7'h04;
  localparam logic [6:0] A_RAD   = 7'h08;
  localparam logic [6:0] A_TXCNT = 7'h0C;
  localparam logic [6:0] A_RXCNT = 7'h10;
  localparam logic [6:0] A_IEN   = 7'h14;
  localparam logic [6:0] A_IPD   = 7'h18;
  localparam logic [1:0] WIN_TX  = 2'b10;
  localparam logic [1:0] WIN_RX  = 2'b11;
endpackage

// File: rtl/i2cseq_regs.sv
`timescale 1ns/1ps
module i2cseq_regs
  import i2cseq_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [6:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic [EV_W-1:0]  evt_set,
  output ctrl_t            ctrl,
  output logic [26:0]      dev_q,
  output logic [26:0]      rad_q,
  output logic [CNT_W-1:0] tx_cnt,
  output logic [CNT_W-1:0] rx_cnt,
  output logic             start_go,
  output logic             tx_go,
  output logic             rx_go,
  output logic [EV_W-1:0]  ien,
  output logic [EV_W-1:0]  ipd,
  output logic             irq
);
  function automatic logic [CNT_W-1:0] clamp(input logic [31:0] v);
    if (v > 32'(BUF_BYTES)) return CNT_W'(BUF_BYTES);
    return v[CNT_W-1:0];
  endfunction

  logic wr_ctrl, wr_ipd;
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_ipd  = reg_wr && (reg_addr == A_IPD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      dev_q    <= '0;
      rad_q    <= '0;
      tx_cnt   <= '0;
      rx_cnt   <= '0;
      ien      <= '0;
      ipd      <= '0;
      start_go <= 1'b0;
      tx_go    <= 1'b0;
      rx_go    <= 1'b0;
    end else begin
      start_go <= wr_ctrl && reg_wdata[3] && reg_wdata[0];
      tx_go    <= reg_wr && (reg_addr == A_TXCNT);
      rx_go    <= reg_wr && (reg_addr == A_RXCNT);
      if (wr_ctrl) ctrl <= ctrl_t'(reg_wdata[6:0]);
      if (reg_wr && reg_addr == A_DEV) dev_q <= reg_wdata[26:0];
      if (reg_wr && reg_addr == A_RAD) rad_q <= reg_wdata[26:0];
      if (reg_wr && reg_addr == A_TXCNT) tx_cnt <= clamp(reg_wdata);
      if (reg_wr && reg_addr == A_RXCNT) rx_cnt <= clamp(reg_wdata);
      if (reg_wr && reg_addr == A_IEN) ien <= reg_wdata[EV_W-1:0];
      ipd <= (ipd & ~(wr_ipd ? reg_wdata[EV_W-1:0] : '0)) | evt_set;
    end
  end

  assign irq = |(ipd & ien);

  p_cnt_clamp_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cnt <= CNT_W'(BUF_BYTES)) && (rx_cnt <= CNT_W'(BUF_BYTES)));
  p_w1c_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ipd && evt_set == '0) |=> (ipd == ($past(ipd) & ~$past(reg_wdata[EV_W-1:0]))));
endmodule

// File: rtl/i2cseq_bufs.sv
`timescale 1ns/1ps
module i2cseq_bufs #(
  parameter int BUF_BYTES = 32,
  parameter int WORDS     = BUF_BYTES / 4,
  parameter int WI_W      = $clog2(WORDS),
  parameter int IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_wr,
  input  logic [WI_W-1:0]  wr_word,
  input  logic [31:0]      wdata,
  input  logic [IDX_W-1:0] tx_idx,
  output logic [7:0]       tx_byte,
  input  logic             rx_we,
  input  logic [IDX_W-1:0] rx_idx,
  input  logic [7:0]       rx_byte,
  input  logic [WI_W-1:0]  rd_word,
  output logic [31:0]      tx_word_o,
  output logic [31:0]      rx_word_o
);
  logic [WORDS*32-1:0] tx_flat;
  logic [WORDS*32-1:0] rx_flat;

  for (genvar w = 0; w < WORDS; w++) begin : g_txw
    logic [31:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else if (tx_wr && wr_word == WI_W'(w)) word_q <= wdata;
    end
    assign tx_flat[w*32 +: 32] = word_q;
  end

  for (genvar b = 0; b < BUF_BYTES; b++) begin : g_rxb
    logic [7:0] byte_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else if (rx_we && rx_idx == IDX_W'(b)) byte_q <= rx_byte;
    end
    assign rx_flat[b*8 +: 8] = byte_q;
  end

  assign tx_byte   = tx_flat[tx_idx*8 +: 8];
  assign tx_word_o = tx_flat[rd_word*32 +: 32];
  assign rx_word_o = rx_flat[rd_word*32 +: 32];
endmodule

// File: rtl/i2cseq_fsm.sv
`timescale 1ns/1ps
module i2cseq_fsm
  import i2cseq_pkg::*;
#(
  parameter int BUF_BYTES = 32,
  parameter int CNT_W     = $clog2(BUF_BYTES + 1),
  parameter int IDX_W     = $clog2(BUF_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl,
  input  logic [26:0]      dev_q,
  input  logic [26:0]      rad_q,
  input  logic [CNT_W-1:0] tx_cnt,
  input  logic [CNT_W-1:0] rx_cnt,
  input  logic             start_go,
  input  logic             tx_go,
  input  logic             rx_go,
  input  logic [7:0]       tx_byte,
  output logic [IDX_W-1:0] tx_idx,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_idx,
  output logic [EV_W-1:0]  evt_set,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic [7:0]       cmd_data,
  output logic             cmd_nack,
  input  logic             rsp_valid,
  output logic             rsp_ready,
  input  logic             rsp_nack
);
  localparam logic [2:0] A_NONE = 3'd6;

  seq_state_e       state;
  logic             waiting;
  logic [CNT_W-1:0] byte_idx;
  logic [2:0]       aidx;
  logic [EV_W-1:0]  evt_q;

  function automatic logic [2:0] seek(input logic [5:0] v, input logic [2:0] from);
    logic [2:0] r;
    r = A_NONE;
    for (int k = 5; k >= 0; k--)
      if (v[k] && k >= int'(from)) r = 3'(k);
    return r;
  endfunction

  logic [5:0]       avalid;
  logic [2:0]       a_first, a_next, aidx_nx;
  logic [7:0]       abyte;
  logic [CNT_W-1:0] idx_nx;
  logic             issuing, rsp_fire, nack_stop, rx_last;
  logic             mode_tx;

  assign avalid   = {rad_q[26:24], dev_q[26:24]};
  assign aidx_nx  = aidx + 3'd1;
  assign a_first  = seek(avalid, 3'd0);
  assign a_next   = seek(avalid, aidx_nx);
  assign idx_nx   = byte_idx + 1'b1;
  assign rx_last  = (idx_nx == rx_cnt);
  assign mode_tx  = (ctrl.mode == MODE_TX);
  assign tx_idx   = byte_idx[IDX_W-1:0];
  assign rx_idx   = byte_idx[IDX_W-1:0];

  always_comb begin
    case (aidx)
      3'd0:    abyte = dev_q[7:0];
      3'd1:    abyte = dev_q[15:8];
      3'd2:    abyte = dev_q[23:16];
      3'd3:    abyte = rad_q[7:0];
      3'd4:    abyte = rad_q[15:8];
      default: abyte = rad_q[23:16];
    endcase
  end

  always_comb begin
    cmd_op   = OP_START;
    cmd_data = 8'h00;
    cmd_nack = 1'b0;
    issuing  = 1'b1;
    case (state)
      S_START, S_RESTART: cmd_op = OP_START;
      S_ADDR:  begin cmd_op = OP_WRITE; cmd_data = abyte; end
      S_RADDR: begin cmd_op = OP_WRITE; cmd_data = dev_q[7:0] | 8'h01; end
      S_TX:    begin cmd_op = OP_WRITE; cmd_data = tx_byte; end
      S_RX:    begin cmd_op = OP_READ; cmd_nack = rx_last && ctrl.last_nack; end
      S_STOP:  cmd_op = OP_STOP;
      default: issuing = 1'b0;
    endcase
  end

  assign cmd_valid = ctrl.en && issuing && !waiting;
  assign rsp_ready = waiting;
  assign rsp_fire  = ctrl.en && waiting && rsp_valid;
  assign nack_stop = rsp_nack && ctrl.act_nack;
  assign rx_we     = rsp_fire && (state == S_RX);
  assign evt_set   = evt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      waiting  <= 1'b0;
      byte_idx <= '0;
      aidx     <= '0;
      evt_q    <= '0;
    end else begin
      evt_q <= '0;
      if (!ctrl.en) begin
        state   <= S_IDLE;
        waiting <= 1'b0;
      end else begin
        if (cmd_valid && cmd_ready) waiting <= 1'b1;
        case (state)
          S_IDLE: if (start_go) state <= S_START;
          S_HOLD: begin
            byte_idx <= '0;
            if (ctrl.stop) state <= S_STOP;
            else if (tx_go && mode_tx) begin
              state <= (tx_cnt == '0) ? S_HOLD : S_TX;
              evt_q[EV_TXDONE] <= (tx_cnt == '0);
            end else if (rx_go && !mode_tx) begin
              state <= (rx_cnt == '0) ? S_HOLD : S_RX;
              evt_q[EV_RXDONE] <= (rx_cnt == '0);
            end
          end
          default: if (rsp_fire) begin
            waiting <= 1'b0;
            case (state)
              S_START: begin
                evt_q[EV_START] <= 1'b1;
                byte_idx <= '0;
                if (mode_tx) begin
                  state <= (tx_cnt == '0) ? S_HOLD : S_TX;
                  evt_q[EV_TXDONE] <= (tx_cnt == '0);
                end else if (ctrl.mode == MODE_REGTX) begin
                  aidx  <= a_first;
                  state <= (a_first == A_NONE) ? S_RESTART : S_ADDR;
                end else begin
                  state <= (rx_cnt == '0) ? S_HOLD : S_RX;
                  evt_q[EV_RXDONE] <= (rx_cnt == '0);
                end
              end
              S_ADDR: begin
                evt_q[EV_BTX] <= 1'b1;
                if (nack_stop) begin
                  evt_q[EV_NACK] <= 1'b1;
                  state <= S_STOP;
                end else begin
                  aidx  <= a_next;
                  state <= (a_next == A_NONE) ? S_RESTART : S_ADDR;
                end
              end
              S_RESTART: begin
                evt_q[EV_START] <= 1'b1;
                state <= S_RADDR;
              end
              S_RADDR: begin
                evt_q[EV_BTX] <= 1'b1;
                byte_idx <= '0;
                if (nack_stop) begin
                  evt_q[EV_NACK] <= 1'b1;
                  state <= S_STOP;
                end else begin
                  state <= (rx_cnt == '0) ? S_HOLD : S_RX;
                  evt_q[EV_RXDONE] <= (rx_cnt == '0);
                end
              end
              S_TX: begin
                evt_q[EV_BTX] <= 1'b1;
                if (nack_stop) begin
                  evt_q[EV_NACK] <= 1'b1;
                  state <= S_STOP;
                end else if (idx_nx == tx_cnt) begin
                  evt_q[EV_TXDONE] <= 1'b1;
                  state <= S_HOLD;
                end else byte_idx <= idx_nx;
              end
              S_RX: begin
                evt_q[EV_BRX] <= 1'b1;
                if (rx_last) begin
                  evt_q[EV_RXDONE] <= 1'b1;
                  state <= S_HOLD;
                end else byte_idx <= idx_nx;
              end
              S_STOP: begin
                evt_q[EV_STOP] <= 1'b1;
                state <= S_IDLE;
              end
              default: state <= S_IDLE;
            endcase
          end
        endcase
      end
    end
  end

  p_cmd_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (!ctrl.en || (cmd_valid && $stable(cmd_op))));
  p_one_outstanding_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> !cmd_valid);
  p_start_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && state != S_START) |=> (state != S_START));
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> (state == S_IDLE && !waiting));
  p_rx_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_READ && cmd_nack) |-> ctrl.last_nack);
endmodule

// File: rtl/i2c_xfer_seq.sv
`timescale 1ns/1ps
module i2c_xfer_seq
  import i2cseq_pkg::*;
#(
  parameter int BUF_BYTES = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [6:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        cmd_valid,
  input  logic        cmd_ready,
  output logic [1:0]  cmd_op,
  output logic [7:0]  cmd_data,
  output logic        cmd_nack,
  input  logic        rsp_valid,
  output logic        rsp_ready,
  input  logic [7:0]  rsp_data,
  input  logic        rsp_nack,
  output logic        irq
);
  localparam int CNT_W = $clog2(BUF_BYTES + 1);
  localparam int IDX_W = $clog2(BUF_BYTES);
  localparam int WORDS = BUF_BYTES / 4;
  localparam int WI_W  = $clog2(WORDS);

  ctrl_t            ctrl;
  logic [26:0]      dev_q, rad_q;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic             start_go, tx_go, rx_go;
  logic [EV_W-1:0]  ien, ipd, evt_set;
  logic [IDX_W-1:0] tx_idx, rx_idx;
  logic [7:0]       tx_byte;
  logic             rx_we;
  logic [31:0]      tx_word, rx_word;
  logic             tx_wr;

  assign tx_wr = reg_wr && (reg_addr[6:5] == WIN_TX);

  i2cseq_regs #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt_set(evt_set), .ctrl(ctrl), .dev_q(dev_q),
    .rad_q(rad_q), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .start_go(start_go),
    .tx_go(tx_go), .rx_go(rx_go), .ien(ien), .ipd(ipd), .irq(irq)
  );

  i2cseq_bufs #(.BUF_BYTES(BUF_BYTES)) u_bufs (
    .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .wr_word(reg_addr[WI_W+1:2]),
    .wdata(reg_wdata), .tx_idx(tx_idx), .tx_byte(tx_byte), .rx_we(rx_we),
    .rx_idx(rx_idx), .rx_byte(rsp_data), .rd_word(reg_addr[WI_W+1:2]),
    .tx_word_o(tx_word), .rx_word_o(rx_word)
  );

  i2cseq_fsm #(.BUF_BYTES(BUF_BYTES), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .dev_q(dev_q), .rad_q(rad_q),
    .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .start_go(start_go), .tx_go(tx_go),
    .rx_go(rx_go), .tx_byte(tx_byte), .tx_idx(tx_idx), .rx_we(rx_we),
    .rx_idx(rx_idx), .evt_set(evt_set), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_nack(cmd_nack), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_nack(rsp_nack)
  );

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[6:5] == WIN_TX) reg_rdata = tx_word;
    else if (reg_addr[6:5] == WIN_RX) reg_rdata = rx_word;
    else begin
      case (reg_addr)
        A_CTRL:  reg_rdata = {25'd0, ctrl};
        A_DEV:   reg_rdata = {5'd0, dev_q};
        A_RAD:   reg_rdata = {5'd0, rad_q};
        A_TXCNT: reg_rdata = 32'(tx_cnt);
        A_RXCNT: reg_rdata = 32'(rx_cnt);
        A_IEN:   reg_rdata = 32'(ien);
        A_IPD:   reg_rdata = 32'(ipd);
        default: reg_rdata = '0;
      endcase
    end
  end

  p_irq_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |-> !irq);
endmodule

// File: tb/i2c_xfer_seq_tb.sv
`timescale 1ns/1ps
module i2c_xfer_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [6:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic cmd_valid, cmd_ready, cmd_nack, rsp_ready, irq;
  logic [1:0] cmd_op;
  logic [7:0] cmd_data;
  logic rsp_valid, rsp_nack;
  logic [7:0] rsp_data;

  always #2 clk = ~clk;

  i2c_xfer_seq u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_data(cmd_data),
    .cmd_nack(cmd_nack), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_nack(rsp_nack), .irq(irq)
  );

  // bit-engine model
  logic stall = 1'b0, clr = 1'b0;
  int   nack_at = -1;
  logic m_busy;
  int   m_lat, n_log, wr_cnt, rd_cnt;
  int   op_log [64];
  int   dat_log [64];
  int   nk_log [64];

  assign cmd_ready = !m_busy && !stall;

  always @(posedge clk) begin
    if (!rst_n || clr) begin
      m_busy <= 1'b0; rsp_valid <= 1'b0; rsp_nack <= 1'b0; rsp_data <= '0;
      n_log <= 0; wr_cnt <= 0; rd_cnt <= 0; m_lat <= 0;
    end else begin
      if (cmd_valid && cmd_ready) begin
        if (n_log < 64) begin
          op_log[n_log] <= int'(cmd_op);
          dat_log[n_log] <= int'(cmd_data);
          nk_log[n_log] <= int'(cmd_nack);
        end
        n_log <= n_log + 1;
        m_busy <= 1'b1; m_lat <= 2;
        rsp_nack <= (cmd_op == 2'd2) && (wr_cnt == nack_at);
        rsp_data <= 8'hC0 + rd_cnt[7:0];
        if (cmd_op == 2'd2) wr_cnt <= wr_cnt + 1;
        if (cmd_op == 2'd3) rd_cnt <= rd_cnt + 1;
      end
      if (m_busy && !rsp_valid) begin
        if (m_lat == 0) rsp_valid <= 1'b1; else m_lat <= m_lat - 1;
      end
      if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0; m_busy <= 1'b0;
      end
    end
  end

  int checks = 0, errors = 0;
  logic [31:0] rv;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic clear_log();
    @(negedge clk); clr = 1'b1; @(negedge clk); clr = 1'b0;
  endtask

  task automatic wait_ev(input int b, input string tag);
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < 3000; i++) begin
      rd(7'h18, v);
      if (v[b]) break;
    end
    check(v[b], tag, int'(v), 1 << b);
  endtask

  task automatic chk_op(input int i, input int op, input int dat, input string tag);
    check(op_log[i] == op && (op != 2 || dat_log[i] == dat), tag,
          op_log[i] * 256 + dat_log[i], op * 256 + dat);
  endtask

  task automatic t_reset();
    rd(7'h00, rv); check(rv == 0, "R1 ctrl reset", int'(rv), 0);
    rd(7'h18, rv); check(rv == 0, "R12 ipd reset", int'(rv), 0);
    check(!irq && !cmd_valid, "R13 idle outputs", int'({irq, cmd_valid}), 0);
  endtask

  task automatic t_transmit();
    clear_log();
    wr(7'h40, 32'h4433_2290); wr(7'h44, 32'h0000_0055);
    rd(7'h40, rv); check(rv == 32'h4433_2290, "R2 tx word readback", int'(rv), 32'h44332290);
    wr(7'h0C, 5); wr(7'h00, 32'h49);
    wait_ev(2, "R3 tx finished");
    check(n_log == 6, "R3 op count", n_log, 6);
    chk_op(0, 0, 0, "R11 start first");
    chk_op(1, 2, 8'h90, "R2 byte0"); chk_op(2, 2, 8'h22, "R2 byte1");
    chk_op(3, 2, 8'h33, "R2 byte2"); chk_op(4, 2, 8'h44, "R2 byte3");
    chk_op(5, 2, 8'h55, "R3 byte4 from word1");
    rd(7'h18, rv); check(rv[6:0] == 7'h15, "R3 R11 event bits", int'(rv), 'h15);
    wr(7'h00, 32'h51);
    wait_ev(5, "R11 stop done");
    chk_op(6, 1, 0, "R11 stop op");
    wr(7'h18, 32'h7F);
  endtask

  task automatic t_regtx();
    clear_log();
    wr(7'h04, 32'h0100_00A0); wr(7'h08, 32'h0300_3412); wr(7'h10, 4);
    wr(7'h00, 32'h7B);
    wait_ev(5, "R4 sequence ends with stop");
    check(n_log == 11, "R4 op count", n_log, 11);
    chk_op(0, 0, 0, "R4 start"); chk_op(1, 2, 8'hA0, "R4 dev byte");
    chk_op(2, 2, 8'h12, "R4 reg byte0"); chk_op(3, 2, 8'h34, "R4 reg byte1");
    chk_op(4, 0, 0, "R4 restart"); chk_op(5, 2, 8'hA1, "R4 read address");
    for (int i = 6; i < 10; i++)
      check(op_log[i] == 3 && nk_log[i] == (i == 9 ? 1 : 0), "R5 read ack choice",
            op_log[i] * 2 + nk_log[i], 6 + (i == 9 ? 1 : 0));
    chk_op(10, 1, 0, "R11 auto stop");
    rd(7'h60, rv); check(rv == 32'hC3C2_C1C0, "R5 R2 rx word0", int'(rv), 32'hC3C2C1C0);
    rd(7'h18, rv); check(rv[3] && rv[1], "R5 rx events", int'(rv), 'h0A);
    rd(7'h00, rv); check(rv == 32'h7B, "R1 ctrl readback", int'(rv), 'h7B);
    wr(7'h18, 32'h7F);
  endtask

  task automatic t_chunks();
    clear_log();
    wr(7'h10, 40);
    rd(7'h10, rv); check(rv == 32, "R8 clamp readback", int'(rv), 32);
    wr(7'h00, 32'h0D);
    wait_ev(3, "R6 chunk1 done");
    check(n_log == 33, "R8 clamped read count", n_log, 33);
    check(nk_log[32] == 0, "R5 last ack when last-NACK clear", nk_log[32], 0);
    rd(7'h7C, rv); check(rv == 32'hDFDE_DDDC, "R2 rx word7", int'(rv), 32'hDFDEDDDC);
    wr(7'h18, 32'h7F);
    wr(7'h00, 32'h25); wr(7'h10, 2);
    wait_ev(3, "R6 chunk2 done");
    check(n_log == 35 && op_log[33] == 3 && nk_log[33] == 0 && nk_log[34] == 1,
          "R6 continuation reads, no start", n_log, 35);
    rd(7'h60, rv); check(rv == 32'hC3C2_E1E0, "R6 R2 lanes of chunk2", int'(rv), 32'hC3C2E1E0);
    wr(7'h00, 32'h35);
    wait_ev(5, "R11 stop after chunks");
    wr(7'h18, 32'h7F);
  endtask

  task automatic t_nack();
    clear_log(); nack_at = 2;
    wr(7'h0C, 5); wr(7'h00, 32'h49);
    wait_ev(6, "R7 nack event");
    wait_ev(5, "R7 stop after nack");
    check(n_log == 5 && op_log[4] == 1, "R7 remaining bytes skipped", n_log, 5);
    rd(7'h18, rv); check(rv[2] == 1'b0, "R7 no tx finished", int'(rv), 'h71);
    wr(7'h18, 32'h7F);
    clear_log(); nack_at = 1;
    wr(7'h00, 32'h19);
    wait_ev(5, "R7 ignore path stops");
    check(n_log == 7, "R7 continue without act", n_log, 7);
    rd(7'h18, rv); check(rv[6] == 1'b0, "R7 no nack event", int'(rv), 0);
    nack_at = -1; wr(7'h18, 32'h7F);
  endtask

  task automatic t_zero();
    clear_log();
    wr(7'h0C, 0); wr(7'h00, 32'h49);
    wait_ev(2, "R8 zero count finishes");
    check(n_log == 1, "R8 zero count no writes", n_log, 1);
    wr(7'h00, 32'h51); wait_ev(5, "R8 stop"); wr(7'h18, 32'h7F);
  endtask

  task automatic t_busy_start();
    clear_log();
    wr(7'h0C, 5); wr(7'h00, 32'h49);
    repeat (6) @(negedge clk);
    wr(7'h00, 32'h49);
    wait_ev(2, "R9 finished");
    check(n_log == 6 && op_log[1] == 2, "R9 no extra start", n_log, 6);
    wr(7'h00, 32'h51); wait_ev(5, "R9 stop"); wr(7'h18, 32'h7F);
  endtask

  task automatic t_abort();
    clear_log(); stall = 1'b1;
    wr(7'h00, 32'h49);
    repeat (4) @(negedge clk);
    check(cmd_valid && cmd_op == 2'd0, "R13 stalled start held", int'({cmd_valid, cmd_op}), 4);
    wr(7'h00, 32'h00);
    check(!cmd_valid, "R10 command dropped", int'(cmd_valid), 0);
    stall = 1'b0; clear_log();
    repeat (3) @(negedge clk);
    check(n_log == 0, "R10 nothing issued while disabled", n_log, 0);
    wr(7'h00, 32'h49);
    wait_ev(2, "R10 restart after abort");
    check(n_log == 6 && op_log[0] == 0, "R10 fresh transfer", n_log, 6);
  endtask

  task automatic t_irq();
    wr(7'h14, 0);
    @(negedge clk); check(!irq, "R12 masked", int'(irq), 0);
    wr(7'h14, 32'h04);
    @(negedge clk); check(irq, "R12 enabled pending", int'(irq), 1);
    wr(7'h18, 32'h04);
    @(negedge clk); check(!irq, "R12 cleared", int'(irq), 0);
    rd(7'h18, rv); check(rv[4] && !rv[2], "R12 only written bit cleared", int'(rv), 'h11);
    wr(7'h00, 32'h51); wait_ev(5, "R12 stop"); wr(7'h18, 32'h7F); wr(7'h14, 0);
  endtask

  logic done = 1'b0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset(); t_transmit(); t_regtx(); t_chunks(); t_nack();
    t_zero(); t_busy_start(); t_abort(); t_irq();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule